// File: doc/BRIEF.md
# Isochronous Interval Descriptor Retirement Engine

This block tracks one isochronous endpoint's chain of transfer descriptors during a single service interval. Before the interval begins, software-side logic fills a local array of up to `NUM_TRB` entries through a load port. Each entry gets a byte count and a chain bit. The descriptor runs from entry 0 up to the first entry whose chain bit is clear. If every entry is chained, it runs to entry `NUM_TRB-1`.

While the interval runs, every completed packet lowers the counts. The engine drains the lowest-indexed entries that still hold bytes first. Bytes left over after the last entry are lost, and this raises a sticky overflow flag. The interval can end in two ways. One is an explicit end strobe, which carries a missed flag. The other applies only to an OUT endpoint: a packet arrives tagged with a later interval number. At the end, the engine emits retirement write-backs one per cycle and then pulses a completion event. Only the first entry and the last entry are ever written back. Middle entries stay owned by hardware and can be reclaimed.

Every write-back on `wb_*` means that entry is retired and its hardware-owned flag is now 0. The count on the port is the entry's residual. The missed bit says whether that residual can be trusted.

Top module: `iso_trb_retire`

## Requirements
- R1: After reset, `wb_valid`, `evt_progress`, `evt_done`, `overflow` and `busy` are all 0.
- R2: In a running interval, an accepted packet of length L is subtracted from the entries, starting at entry 0 and going up to the last entry. Each entry gives up at most its own count. `evt_progress` pulses for exactly one cycle, in the cycle after the packet is presented.
- R3: If a packet is larger than all remaining counts combined, every entry drains to 0 and the excess is dropped. `overflow` rises in the cycle after that packet and stays high until the next interval start.
- R4: The first entry can be retired early when the descriptor has more than one entry. This happens in the cycle after an accepted packet leaves entry 0 at count 0: a write-back appears with index 0, count 0 and missed 0. Entry 0 is never written back again in that interval.
- R5: At interval end, if entry 0 is not yet retired and the descriptor has more than one entry, a write-back of index 0 comes first. It carries the entry's residual count and missed 0.
- R6: The last entry is always written back at interval end, after any index-0 write-back. It carries its residual count and the missed flag of the end event. No index between 0 and the last entry is ever written back.
- R7: `evt_done` pulses one cycle after the final write-back, and `busy` is 0 from that cycle on.
- R8: For an OUT endpoint (`start_out`=1), a packet whose `pkt_ival` is greater (unsigned) than `start_ival` is not counted. Instead it ends the interval with missed=1. A packet with an equal or smaller number is counted normally. An IN endpoint counts every packet whatever its number.
- R9: When `iend_valid` and `pkt_valid` are presented in the same cycle, the end wins and the packet is not counted.
- R10: Loads and packets presented while the block is idle have no effect on any output. Loads presented while the block is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Write one descriptor entry (idle only) |
| ld_idx | input | IDX_W | Entry index to load |
| ld_count | input | CNT_W | Byte count for the entry |
| ld_chain | input | 1 | Chain bit: 1 = the next entry belongs to the descriptor |
| start | input | 1 | Begin an interval (idle only) |
| start_out | input | 1 | 1 = OUT endpoint, 0 = IN endpoint |
| start_ival | input | IV_W | Number of the interval being served |
| pkt_valid | input | 1 | Packet completed |
| pkt_len | input | CNT_W | Byte length of the packet |
| pkt_ival | input | IV_W | Interval number tagged on the packet |
| iend_valid | input | 1 | Interval end strobe |
| iend_missed | input | 1 | The interval ended with a miss |
| wb_valid | output | 1 | Retirement write-back valid |
| wb_idx | output | IDX_W | Index of the retired entry |
| wb_count | output | CNT_W | Residual byte count |
| wb_missed | output | 1 | Residual is unreliable |
| evt_progress | output | 1 | One-cycle pulse per counted packet |
| evt_done | output | 1 | One-cycle pulse when retirement is finished |
| overflow | output | 1 | Sticky: packet bytes were dropped after the last entry |
| busy | output | 1 | An interval or its retirement is in progress |

## Verification
The array is only visible through the residuals reported at retirement. A subtraction error or a wrong carry order therefore shows up as a wrong `wb_count` on index 0 or on the last index. That happens at the end of the same interval, or one cycle after the packet when entry 0 retires early. A wrong last-index decode shows up at once as a write-back to the wrong index. A lost first-retired flag shows up as a duplicate index-0 write-back. A wrong state transition shows up as `evt_done` or `busy` off by a cycle, or missing within the few cycles after the end strobe.

// File: rtl/iso_trb_retire.sv
module iso_trb_retire #(
  parameter int NUM_TRB = 8,
  parameter int CNT_W   = 16,
  parameter int IV_W    = 14,
  localparam int IDX_W  = (NUM_TRB > 1) ? $clog2(NUM_TRB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             ld_chain,
  input  logic             start,
  input  logic             start_out,
  input  logic [IV_W-1:0]  start_ival,
  input  logic             pkt_valid,
  input  logic [CNT_W-1:0] pkt_len,
  input  logic [IV_W-1:0]  pkt_ival,
  input  logic             iend_valid,
  input  logic             iend_missed,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [CNT_W-1:0] wb_count,
  output logic             wb_missed,
  output logic             evt_progress,
  output logic             evt_done,
  output logic             overflow,
  output logic             busy
);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_WB0, S_WBL, S_FIN} st_t;
  st_t state;

  logic [CNT_W-1:0] cnt   [NUM_TRB];
  logic [CNT_W-1:0] nxt   [NUM_TRB];
  logic [NUM_TRB-1:0] chain;
  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] spill;
  logic             first_ret, miss_q, ep_out;
  logic [IV_W-1:0]  cur_ival;

  assign busy = (state != S_IDLE);

  always_comb begin
    last_idx = IDX_W'(NUM_TRB - 1);
    for (int i = NUM_TRB - 1; i >= 0; i--)
      if (!chain[i]) last_idx = IDX_W'(i);
  end

  always_comb begin : drain
    logic [CNT_W-1:0] rem, take;
    rem = pkt_len;
    for (int i = 0; i < NUM_TRB; i++) begin
      nxt[i] = cnt[i];
      if (IDX_W'(i) <= last_idx) begin
        take   = (rem < cnt[i]) ? rem : cnt[i];
        nxt[i] = cnt[i] - take;
        rem    = rem - take;
      end
    end
    spill = rem;
  end

  wire late_pkt  = pkt_valid && ep_out && (pkt_ival > cur_ival);
  wire skip_wb0  = first_ret || (last_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      chain        <= '0;
      first_ret    <= 1'b0;
      miss_q       <= 1'b0;
      ep_out       <= 1'b0;
      cur_ival     <= '0;
      overflow     <= 1'b0;
      wb_valid     <= 1'b0;
      wb_idx       <= '0;
      wb_count     <= '0;
      wb_missed    <= 1'b0;
      evt_progress <= 1'b0;
      evt_done     <= 1'b0;
      for (int i = 0; i < NUM_TRB; i++) cnt[i] <= '0;
    end else begin
      wb_valid     <= 1'b0;
      evt_progress <= 1'b0;
      evt_done     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ld_valid) begin
            cnt[ld_idx]   <= ld_count;
            chain[ld_idx] <= ld_chain;
          end
          if (start) begin
            state     <= S_RUN;
            first_ret <= 1'b0;
            overflow  <= 1'b0;
            miss_q    <= 1'b0;
            ep_out    <= start_out;
            cur_ival  <= start_ival;
          end
        end
        S_RUN: begin
          if (iend_valid || late_pkt) begin
            miss_q <= iend_valid ? iend_missed : 1'b1;
            state  <= skip_wb0 ? S_WBL : S_WB0;
          end else if (pkt_valid) begin
            for (int i = 0; i < NUM_TRB; i++) cnt[i] <= nxt[i];
            evt_progress <= 1'b1;
            if (spill != '0) overflow <= 1'b1;
            if (!skip_wb0 && nxt[0] == '0) begin
              first_ret <= 1'b1;
              wb_valid  <= 1'b1;
              wb_idx    <= '0;
              wb_count  <= '0;
              wb_missed <= 1'b0;
            end
          end
        end
        S_WB0: begin
          first_ret <= 1'b1;
          wb_valid  <= 1'b1;
          wb_idx    <= '0;
          wb_count  <= cnt[0];
          wb_missed <= 1'b0;
          state     <= S_WBL;
        end
        S_WBL: begin
          wb_valid  <= 1'b1;
          wb_idx    <= last_idx;
          wb_count  <= cnt[last_idx];
          wb_missed <= miss_q;
          state     <= S_FIN;
        end
        S_FIN: begin
          evt_done <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module iso_trb_retire_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             pkt_valid,
  input logic             wb_valid,
  input logic [IDX_W-1:0] wb_idx,
  input logic             wb_missed,
  input logic             evt_progress,
  input logic             evt_done,
  input logic             overflow,
  input logic [IDX_W-1:0] last_idx
);
  logic seen0;
  always_ff @(posedge clk) begin
    if (!rst_n || (start && !busy)) seen0 <= 1'b0;
    else if (wb_valid && wb_idx == '0) seen0 <= 1'b1;
  end

  // R2
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_progress |-> $past(pkt_valid));
  // R3
  overflow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(pkt_valid));
  // R4
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_idx == '0 && last_idx != '0) |-> !seen0);
  // R6
  wb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx == '0 || wb_idx == last_idx));
  // R6
  missed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_missed) |-> (wb_idx == last_idx));
  // R7
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> ($past(wb_valid) && !busy));
  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_done && wb_valid));
endmodule

bind iso_trb_retire iso_trb_retire_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pkt_valid(pkt_valid),
  .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_missed(wb_missed),
  .evt_progress(evt_progress), .evt_done(evt_done), .overflow(overflow),
  .last_idx(last_idx));

// File: tb/tb_iso_trb_retire.sv
module tb_iso_trb_retire;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IDX_W = 3;
  localparam int CNT_W = 16;
  localparam int IV_W = 14;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_chain = 0, start = 0, start_out = 0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [CNT_W-1:0] ld_count = '0, pkt_len = '0;
  logic [IV_W-1:0] start_ival = '0, pkt_ival = '0;
  logic pkt_valid = 0, iend_valid = 0, iend_missed = 0;
  logic wb_valid, wb_missed, evt_progress, evt_done, overflow, busy;
  logic [IDX_W-1:0] wb_idx;
  logic [CNT_W-1:0] wb_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_trb_retire dut (.*);

  int errors = 0, checks = 0;
  int mc[N]; int mlast; bit mfr, movf, mout; int mival;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_desc(int n, int c[N]);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_valid = 1; ld_idx = IDX_W'(i);
      ld_count = CNT_W'(c[i]);
      ld_chain = (i < n-1) ? 1'b1 : (i == n-1 ? 1'b0 : 1'($urandom));
      mc[i] = c[i];
    end
    @(negedge clk); ld_valid = 0;
    mlast = n-1;
  endtask

  task automatic begin_ival(bit out, int iv);
    @(negedge clk);
    start = 1; start_out = out; start_ival = IV_W'(iv);
    @(negedge clk); start = 0;
    mfr = 0; movf = 0; mout = out; mival = iv;
    chk(busy == 1, "R10", "busy after start", busy, 1);
  endtask

  function automatic bit model_pkt(int len);
    int rem = len;
    for (int i = 0; i <= mlast; i++) begin
      int t = (rem < mc[i]) ? rem : mc[i];
      mc[i] -= t; rem -= t;
    end
    if (rem > 0) movf = 1;
    if (mlast != 0 && !mfr && mc[0] == 0) begin mfr = 1; return 1; end
    return 0;
  endfunction

  task automatic collect(bit missed);
    int ei[2], ec[2], em[2], ne = 0, got = 0;
    bit done = 0;
    if (!mfr && mlast != 0) begin ei[ne] = 0; ec[ne] = mc[0]; em[ne] = 0; ne++; end
    ei[ne] = mlast; ec[ne] = mc[mlast]; em[ne] = missed; ne++;
    for (int k = 0; k < 6 && !done; k++) begin
      if (wb_valid) begin
        if (got < ne) begin
          chk(wb_idx == IDX_W'(ei[got]), got == 0 && ne == 2 ? "R5" : "R6", "wb index", wb_idx, ei[got]);
          chk(wb_count == CNT_W'(ec[got]), got == 0 && ne == 2 ? "R5" : "R6", "wb count", wb_count, ec[got]);
          chk(wb_missed == em[got][0], "R6", "wb missed", wb_missed, em[got]);
        end
        got++;
      end
      if (evt_done) begin
        done = 1;
        chk(busy == 0, "R7", "busy at done", busy, 0);
      end
      if (!done) @(negedge clk);
    end
    chk(done, "R7", "done pulse seen", done, 1);
    chk(got == ne, "R6", "write-back count", got, ne);
    mfr = 1;
  endtask

  task automatic send_pkt(int len, int iv);
    bit late = mout && (iv > mival);
    bit ew;
    @(negedge clk);
    pkt_valid = 1; pkt_len = CNT_W'(len); pkt_ival = IV_W'(iv);
    @(negedge clk); pkt_valid = 0;
    if (late) begin
      chk(evt_progress == 0, "R8", "late packet not counted", evt_progress, 0);
      collect(1);
    end else begin
      ew = model_pkt(len);
      chk(evt_progress == 1, "R2", "progress pulse", evt_progress, 1);
      chk(wb_valid == ew, "R4", "early retire", wb_valid, ew);
      if (ew) chk(wb_idx == 0 && wb_count == 0 && !wb_missed, "R4", "early wb fields", wb_count, 0);
      chk(overflow == movf, "R3", "overflow flag", overflow, movf);
    end
  endtask

  task automatic end_ival(bit missed, bit with_pkt);
    @(negedge clk);
    iend_valid = 1; iend_missed = missed;
    if (with_pkt) begin pkt_valid = 1; pkt_len = 16'd1; pkt_ival = IV_W'(mival); end
    @(negedge clk); iend_valid = 0; pkt_valid = 0;
    if (with_pkt) chk(evt_progress == 0, "R9", "packet beside end", evt_progress, 0);
    collect(missed);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c[N];
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!wb_valid && !evt_progress && !evt_done && !overflow && !busy, "R1", "reset outputs", {wb_valid, evt_done, overflow, busy}, 0);

    // R10: idle packet has no effect
    @(negedge clk); pkt_valid = 1; pkt_len = 5;
    @(negedge clk); pkt_valid = 0;
    chk(evt_progress == 0 && busy == 0, "R10", "idle packet ignored", evt_progress, 0);

    // R2/R4/R6: carry and middle entry untouched
    c = '{10, 20, 30, 0, 0, 0, 0, 0};
    load_desc(3, c); begin_ival(0, 1);
    send_pkt(10, 1); send_pkt(25, 1); end_ival(0, 0);

    // R3: overflow
    c = '{5, 5, 0, 0, 0, 0, 0, 0};
    load_desc(2, c); begin_ival(0, 2);
    send_pkt(15, 2); end_ival(1, 0);

    // R5 and R10: first not retired, busy load ignored
    c = '{50, 1, 1, 0, 0, 0, 0, 0};
    load_desc(3, c); begin_ival(0, 3);
    send_pkt(10, 3);
    @(negedge clk); ld_valid = 1; ld_idx = 0; ld_count = 999; ld_chain = 0;
    @(negedge clk); ld_valid = 0;
    end_ival(0, 0);

    // R8: OUT late packet, earlier number still counted
    c = '{10, 10, 0, 0, 0, 0, 0, 0};
    load_desc(2, c); begin_ival(1, 5);
    send_pkt(3, 5); send_pkt(2, 4); send_pkt(4, 6);

    // R8: IN ignores number
    load_desc(2, c); begin_ival(0, 5);
    send_pkt(3, 9); end_ival(0, 0);

    // R9
    load_desc(2, c); begin_ival(0, 7);
    send_pkt(4, 7); end_ival(0, 1);

    // single entry: no early retire
    c = '{8, 0, 0, 0, 0, 0, 0, 0};
    load_desc(1, c); begin_ival(0, 8);
    send_pkt(8, 8); end_ival(1, 0);

    // random intervals
    for (int t = 0; t < 200; t++) begin
      int n = 1 + int'($urandom % N);
      bit o = 1'($urandom);
      for (int i = 0; i < N; i++) c[i] = int'($urandom % 41);
      load_desc(n, c); begin_ival(o, 100);
      for (int p = 0; p < int'($urandom % 6) && busy; p++) begin
        int iv = (o && ($urandom % 8 == 0)) ? 101 : 100;
        send_pkt(int'($urandom % 31), iv);
      end
      if (busy) end_ival(1'($urandom), ($urandom % 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule